// File: doc/BRIEF.md
# Poison-Tracking Register File

This block is an architectural register file in which every entry keeps a poison mark next to its data word. A producer whose result may be wrong (for example, it issued from a storage structure that detected a parity fault) writes with its poison input set. The value is stored and the destination is marked. The error is not raised at write or commit time. Poison simply travels with the value.

An error is reported only when a consumer actually reads a poisoned entry through an enabled read port. If a later clean write replaces the poisoned value before anyone reads it, the value was dynamically dead. Its mark is dropped and no error is ever reported. Each read port has its own error flag.

Reads are combinational. A read that names the register being written in the same cycle sees the incoming data and its incoming poison. A global clear input wipes every poison mark in a single cycle.

Top module: `prf_core`

## Requirements
- R1: After reset every register reads as zero and no read port reports an error.
- R2: A write with the poison input high to a non-zero index stores the data and marks that register poisoned. An enabled read of it afterwards returns the data with its port error high, and this holds on every such read.
- R3: A write with the poison input low stores the data and clears that register's poison mark.
- R4: A poisoned register that is overwritten by a clean write before any enabled read never raises an error on any later read.
- R5: Register index 0 always reads as zero with error low, and writes to index 0 change nothing.
- R6: When a read port selects the index being written in the same cycle (non-zero index), it returns the write data. Its error equals the write's poison input, gated by the global clear and by that port's enable.
- R7: A port's error output is low whenever that port's read enable is low, and its data output still shows the selected register.
- R8: A cycle with the global clear high leaves every register unpoisoned afterwards, while the data is kept. A write in the same cycle stores its data unpoisoned, because the clear takes priority over the poison input.
- R9: The two read ports are independent: each port's data and error depend only on its own index and enable.
- R10: Reads never change the state: a cycle with no write and no clear leaves every poison mark as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Clears all poison marks at the next edge |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write data |
| wr_poison | input | 1 | Marks the written value as possibly incorrect |
| rd_en | input | 2 | Read enable, one bit per port |
| rd_idx | input | 10 | Read indices; port p uses bits [5p+4:5p] |
| rd_data | output | 128 | Read data; port p uses bits [64p+63:64p] |
| rd_err | output | 2 | Poisoned-read error, one bit per port |

## Verification
The bench builds the block with its defaults: 32 registers of 64 bits and two read ports. This brings both ends of the index range within reach: the hard-wired zero register and the top register 31. The two ports can be driven with different enables and targets in the same cycle. The sequences cover the paths a poison mark can take: poisoned then read, poisoned then overwritten unread, poisoned then globally cleared, and clear colliding with a poisoned write, including same-cycle bypass on both ports.

// File: rtl/prf_pkg.sv
package prf_pkg;
    localparam int PRF_DEF_REGS  = 32;
    localparam int PRF_DEF_WIDTH = 64;
    localparam int PRF_DEF_RD    = 2;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/prf_wr_ctl.sv
// Qualifies the write request: index 0 is never written, clear beats poison.
module prf_wr_ctl #(
    parameter int IDX_W = 5
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_poison,
    input  logic             clr_all,
    output logic             we_eff,
    output logic             pois_eff
);
    always_comb begin
        we_eff   = wr_en && (wr_idx != '0);
        pois_eff = wr_poison && !clr_all;
    end
endmodule

// File: rtl/prf_store.sv
// Data and poison state, two-process style.
module prf_store #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int IDX_W    = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr_all,
    input  logic                              we_eff,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              pois_eff,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q,
    output logic [NUM_REGS-1:0]               poison_q
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] data;
        logic [NUM_REGS-1:0]             poison;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_all) begin
            state_d.poison = '0;
        end
        if (we_eff) begin
            state_d.data[wr_idx]   = wr_data;
            state_d.poison[wr_idx] = pois_eff;
        end
        state_d.data[0]   = '0;
        state_d.poison[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign regs_q   = state_q.data;
    assign poison_q = state_q.poison;
endmodule

// File: rtl/prf_rd_port.sv
// One read port with same-cycle write bypass and a per-port error flag.
module prf_rd_port #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int IDX_W    = 5
) (
    input  logic                              rd_en,
    input  logic [IDX_W-1:0]                  rd_idx,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q,
    input  logic [NUM_REGS-1:0]               poison_q,
    input  logic                              we_eff,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              pois_eff,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_err
);
    logic hit;
    logic sel_pois;

    always_comb begin
        hit = we_eff && (wr_idx == rd_idx);
        if (rd_idx == '0) begin
            rd_data  = '0;
            sel_pois = 1'b0;
        end else if (hit) begin
            rd_data  = wr_data;
            sel_pois = pois_eff;
        end else begin
            rd_data  = regs_q[rd_idx];
            sel_pois = poison_q[rd_idx];
        end
        rd_err = rd_en && sel_pois;
    end
endmodule

// File: rtl/prf_core.sv
module prf_core #(
    parameter int NUM_REGS = prf_pkg::PRF_DEF_REGS,
    parameter int DATA_W   = prf_pkg::PRF_DEF_WIDTH,
    parameter int NUM_RD   = prf_pkg::PRF_DEF_RD,
    localparam int IDX_W   = prf_pkg::idx_bits(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_all,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     wr_poison,
    input  logic [NUM_RD-1:0]        rd_en,
    input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
    output logic [NUM_RD*DATA_W-1:0] rd_data,
    output logic [NUM_RD-1:0]        rd_err
);
    logic                            we_eff;
    logic                            pois_eff;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_REGS-1:0]             poison_vec;

    prf_wr_ctl #(.IDX_W(IDX_W)) wr_ctl_i (
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_poison (wr_poison),
        .clr_all   (clr_all),
        .we_eff    (we_eff),
        .pois_eff  (pois_eff)
    );

    prf_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .we_eff   (we_eff),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .pois_eff (pois_eff),
        .regs_q   (regs_q),
        .poison_q (poison_vec)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        prf_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) port_i (
            .rd_en    (rd_en[p]),
            .rd_idx   (rd_idx[p*IDX_W +: IDX_W]),
            .regs_q   (regs_q),
            .poison_q (poison_vec),
            .we_eff   (we_eff),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .pois_eff (pois_eff),
            .rd_data  (rd_data[p*DATA_W +: DATA_W]),
            .rd_err   (rd_err[p])
        );
    end
endmodule

// File: rtl/prf_core_chk.sv
module prf_core_chk #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 64,
    parameter int NUM_RD   = 2,
    parameter int IDX_W    = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clr_all,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     wr_poison,
    input logic [NUM_RD-1:0]        rd_en,
    input logic [NUM_RD*IDX_W-1:0]  rd_idx,
    input logic [NUM_RD*DATA_W-1:0] rd_data,
    input logic [NUM_RD-1:0]        rd_err,
    input logic [NUM_REGS-1:0]      poison_vec
);
    // R2
    poison_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_poison && !clr_all && wr_idx != '0) |=> poison_vec[$past(wr_idx)]);

    // R3
    clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_poison && wr_idx != '0) |=> !poison_vec[$past(wr_idx)]);

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx[IDX_W-1:0] == '0) |-> (rd_data[DATA_W-1:0] == '0 && !rd_err[0]));

    // R6
    bypass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0 && rd_idx[IDX_W-1:0] == wr_idx)
            |-> (rd_data[DATA_W-1:0] == wr_data));

    // R7
    gated_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en[0] |-> !rd_err[0]);

    // R8
    global_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (poison_vec == '0));

    // R10
    read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_all) |=> $stable(poison_vec));
endmodule

bind prf_core prf_core_chk #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_poison(wr_poison), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_err(rd_err), .poison_vec(poison_vec)
);

// File: tb/prf_core_tb_top.sv
`timescale 1ns/1ps
module prf_core_tb_top;
    localparam int NR = 32;
    localparam int DW = 64;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_all = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_poison = 1'b0;
    logic [1:0]    rd_en = '0;
    logic [2*IW-1:0] rd_idx = '0;
    logic [2*DW-1:0] rd_data;
    logic [1:0]    rd_err;

    always #10 clk = ~clk;  // 50 MHz

    prf_core dut_i (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_poison(wr_poison),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err)
    );

    typedef struct {
        int          port;
        logic [DW-1:0] d;
        logic        e;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    event  sample_ev;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    logic [DW-1:0] ref_data [NR];
    logic          ref_pois [NR];

    // Monitor: pops expectations and compares with the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                exp_t x;
                logic [DW-1:0] ad;
                logic ae;
                x  = sb_q.pop_front();
                ad = rd_data[x.port*DW +: DW];
                ae = rd_err[x.port];
                n_vec++;
                if (ad !== x.d || ae !== x.e) begin
                    n_bad++;
                    $display("FAIL %s port%0d: data=%h err=%b expected data=%h err=%b",
                             x.tag, x.port, ad, ae, x.d, x.e);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, expected values from the reference model.
    task automatic cycle(input bit we, input int widx, input logic [DW-1:0] wdata,
                         input bit wp, input bit clr, input bit e0, input int i0,
                         input bit e1, input int i1, input string tag);
        int idx [2];
        bit en [2];
        @(negedge clk);
        wr_en = we; wr_idx = widx[IW-1:0]; wr_data = wdata; wr_poison = wp;
        clr_all = clr;
        rd_en = {e1, e0};
        rd_idx = {i1[IW-1:0], i0[IW-1:0]};
        idx[0] = i0; idx[1] = i1; en[0] = e0; en[1] = e1;
        for (int p = 0; p < 2; p++) begin
            exp_t x;
            x.port = p;
            x.tag  = tag;
            if (idx[p] == 0) begin
                x.d = '0; x.e = 1'b0;
            end else if (we && widx == idx[p]) begin
                x.d = wdata; x.e = en[p] && wp && !clr;
            end else begin
                x.d = ref_data[idx[p]]; x.e = en[p] && ref_pois[idx[p]];
            end
            sb_q.push_back(x);
        end
        #5;
        ->sample_ev;
        if (clr) for (int r = 0; r < NR; r++) ref_pois[r] = 1'b0;
        if (we && widx != 0) begin
            ref_data[widx] = wdata;
            ref_pois[widx] = wp && !clr;
        end
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin ref_data[r] = '0; ref_pois[r] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cycle(0, 0, '0, 0, 0, 1, 1, 1, 31, "R1 reset");
        cycle(0, 0, '0, 0, 0, 1, 17, 1, 0, "R1 reset");

        // R2: poisoned write then repeated reads
        cycle(1, 5, 64'hDEAD_BEEF_0000_0005, 1, 0, 0, 1, 0, 2, "R2 write");
        cycle(0, 0, '0, 0, 0, 1, 5, 1, 5, "R2 read");
        cycle(0, 0, '0, 0, 0, 1, 5, 0, 1, "R2 reread R10");
        cycle(0, 0, '0, 0, 0, 1, 5, 1, 5, "R10 still poisoned");

        // R3/R4: dead poisoned value overwritten clean
        cycle(1, 7, 64'h7777_0000_1111_2222, 1, 0, 0, 7, 0, 7, "R4 poison");
        cycle(1, 7, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, 0, 0, "R4 overwrite");
        cycle(0, 0, '0, 0, 0, 1, 7, 1, 7, "R4 R3 read clean");

        // R5: index 0 ignores writes
        cycle(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 1, 0, 1, 0, "R5 write zero");
        cycle(0, 0, '0, 0, 0, 1, 0, 1, 0, "R5 read zero");

        // R6: same-cycle bypass on both ports, then registered
        cycle(1, 9, 64'h9999_AAAA_BBBB_CCCC, 1, 0, 1, 9, 1, 9, "R6 bypass poisoned");
        cycle(1, 9, 64'h1234_0000_0000_0009, 0, 0, 1, 9, 0, 9, "R6 bypass clean");
        cycle(0, 0, '0, 0, 0, 1, 9, 1, 9, "R6 after");

        // R7: enable low hides error, data still shown
        cycle(0, 0, '0, 0, 0, 0, 5, 1, 5, "R7 gated");

        // R9: independent ports
        cycle(1, 31, 64'h3131_3131_3131_3131, 1, 0, 0, 0, 0, 0, "R9 setup");
        cycle(0, 0, '0, 0, 0, 1, 31, 1, 7, "R9 mixed");
        cycle(0, 0, '0, 0, 0, 1, 7, 1, 31, "R9 swapped");

        // R8: clear colliding with poisoned write
        cycle(1, 12, 64'hC1C1_C1C1_0000_0012, 1, 0, 0, 0, 0, 0, "R8 setup");
        cycle(1, 20, 64'h2020_2020_2020_2020, 1, 1, 1, 20, 1, 12, "R8 clear cycle");
        cycle(0, 0, '0, 0, 0, 1, 12, 1, 20, "R8 after clear");
        cycle(0, 0, '0, 0, 0, 1, 5, 1, 31, "R8 data kept");
        cycle(0, 0, '0, 0, 0, 1, 9, 1, 0, "R8 R10 idle");

        @(negedge clk);
        #6;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule